// File: doc/BRIEF.md
# Sink Scrambling Setup Sequencer

This block runs once for each new video mode on a display transmitter. It decides whether the mode runs fast enough to need line scrambling. It then sets up the receiving sink through that sink's status-and-control register space. The sequencer does not drive the two-wire bus itself. It hands single-byte read and write requests to a separate bus engine over a request/response handshake, and that engine reports acknowledge or failure for each attempt.

A start pulse samples two inputs: the pixel rate in kHz and the transmitter version word. If the version is too old, the sequencer finishes at once and does nothing. If the version is new enough, the sequencer reads the sink's configuration byte. It changes only the bit it owns and writes the byte back, retrying failed attempts a bounded number of times. It also holds a fixed settling gap after every attempt. On the high-rate path it first raises the bit-clock ratio, then turns on the local scrambler and datapath update, and finally turns on scrambling in the sink. On the low-rate path it only clears the sink's scrambling bit.

When the sequence ends, a done flag rises. An error flag and the final scrambling state sit beside it, and all three hold until the next start.

Top module: `scdc_scramble_seq`

## Requirements
- R1: When the top 4 bits of `tx_version` are below 4, a start ends in the done state within one cycle. In that case error stays 0, no request is issued, and `scramble_en`, `path_update` and `scramble_state` stay 0.
- R2: The high-rate path is taken only when `pix_khz` is strictly greater than 340000. A rate of exactly 340000 takes the low-rate path.
- R3: Every request carries device address 0xA8 and register offset 0x20. While a request waits for `req_ready`, its fields do not change.
- R4: Each write is a read-modify-write of the configuration byte, and the write data equals the byte just read with exactly one bit replaced. The clock-ratio write replaces bit 1 (set to 1). The scrambling write replaces bit 0 (1 on the high-rate path, 0 on the low-rate path).
- R5: On the high-rate path the order is: read, clock-ratio write, local `scramble_en` and `path_update` set to 1, read, scrambling write. `scramble_en` is 0 when the clock-ratio write is issued and 1 when the second read is issued.
- R6: A read is attempted at most 3 times and a write at most 2 times. An attempt fails when the response has `rsp_ok` = 0; `rsp_ok` = 1 means acknowledge. When the attempts are used up, the sequence ends with error = 1 and issues no further request.
- R7: After every response there are at least GAP_CYCLES clock cycles before the next request is presented or the done state is entered.
- R8: On the low-rate path the sequence is one read and one write with bit 0 cleared. `scramble_en` and `path_update` stay 0.
- R9: `done` and `error` hold their value until the next start. A start that arrives while a sequence is running is ignored. An accepted start clears `error`.
- R10: `scramble_state` becomes 1 only when the high-rate path completes without error. It is 0 after any other outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (ignored while busy) |
| pix_khz | input | RATE_W | Pixel rate of the new mode in kHz |
| tx_version | input | VER_W | Transmitter version word, major in the top 4 bits |
| req_valid | output | 1 | Bus request presented |
| req_write | output | 1 | 1 = write, 0 = read |
| req_dev | output | 8 | Device address of the sink |
| req_offset | output | 8 | Register offset in the sink |
| req_wdata | output | 8 | Byte to write |
| req_ready | input | 1 | Bus engine accepts the request |
| rsp_valid | input | 1 | Response for the accepted request |
| rsp_ok | input | 1 | 1 = acknowledged, 0 = failed |
| rsp_rdata | input | 8 | Byte read from the sink |
| scramble_en | output | 1 | Local scrambler enable |
| path_update | output | 1 | Local datapath-mode update control |
| done | output | 1 | Sequence finished (held) |
| error | output | 1 | Sequence finished on a failed access (held) |
| scramble_state | output | 1 | Scrambling finally active in the sink and locally |

## Verification
A new start pulse can arrive in the same cycle as the bus engine's response to a running sequence. The block must keep finishing the running sequence and must not restart. The bench raises start exactly in the cycle where the first read's response is valid. It then judges the run by the transaction log, which must show exactly the four accesses of one high-rate sequence with the expected write bytes, and by the absence of any further request once done is seen. A second overlap is between a failed response and the retry decision at the end of the settling gap. Injected failures at chosen attempt indexes check that the retry count and the gap length both hold across that boundary.

// File: rtl/scdc_seq_pkg.sv
package scdc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_RATIO,
      ST_WR_RATIO,
      ST_LOCAL,
      ST_RD_SCR,
      ST_WR_SCR,
      ST_FIN
   } seq_state_e;

   typedef enum logic [1:0] {
      XA_IDLE,
      XA_REQ,
      XA_RSP,
      XA_GAP
   } xfer_state_e;

   localparam int unsigned RATIO_BIT = 1;
   localparam int unsigned SCR_BIT   = 0;

   function automatic logic [7:0] patch_bit(input logic [7:0] b,
                                            input int unsigned pos,
                                            input logic v);
      logic [7:0] r;
      r      = b;
      r[pos] = v;
      return r;
   endfunction

endpackage

// File: rtl/scdc_gap_timer.sv
module scdc_gap_timer #(
   parameter int unsigned GAP_CYCLES = 117000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic last
);
   generate
      if (GAP_CYCLES == 0) begin : g_no_gap
         assign last = 1'b1;
         logic unused_gap_in;
         assign unused_gap_in = load ^ clk ^ rst_n;
      end else begin : g_counter
         localparam int unsigned CW = $clog2(GAP_CYCLES + 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (load) begin
               cnt <= CW'(GAP_CYCLES);
            end else if (cnt != '0) begin
               cnt <= cnt - 1'b1;
            end
         end

         assign last = (cnt == CW'(1));
      end
   endgenerate
endmodule

// File: rtl/scdc_mode_gate.sv
module scdc_mode_gate #(
   parameter int unsigned VER_W       = 32,
   parameter int unsigned VER_FIELD_W = 4,
   parameter int unsigned MIN_VER     = 4,
   parameter int unsigned RATE_W      = 32,
   parameter int unsigned THRESH_KHZ  = 340000
) (
   input  logic [VER_W-1:0]  tx_version,
   input  logic [RATE_W-1:0] pix_khz,
   output logic              ver_ok,
   output logic              hi_rate
);
   localparam int unsigned VER_LSB = VER_W - VER_FIELD_W;

   logic [VER_FIELD_W-1:0] major;

   generate
      if (VER_LSB == 0) begin : g_whole
         assign major = tx_version;
      end else begin : g_slice
         assign major = tx_version[VER_W-1:VER_LSB];
         logic unused_low_ver;
         assign unused_low_ver = ^tx_version[VER_LSB-1:0];
      end
   endgenerate

   assign ver_ok  = (major >= VER_FIELD_W'(MIN_VER));
   assign hi_rate = (pix_khz > RATE_W'(THRESH_KHZ));
endmodule

// File: rtl/scdc_xfer_agent.sv
module scdc_xfer_agent
   import scdc_seq_pkg::*;
#(
   parameter logic [7:0]  DEV_ADDR   = 8'hA8,
   parameter logic [7:0]  REG_OFS    = 8'h20,
   parameter int unsigned TRY_W      = 2,
   parameter int unsigned GAP_CYCLES = 117000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             go_write,
   input  logic [7:0]       go_wdata,
   input  logic [TRY_W-1:0] go_tries,
   output logic             fin,
   output logic             fin_ok,
   output logic [7:0]       fin_rdata,
   output logic             req_valid,
   output logic             req_write,
   output logic [7:0]       req_dev,
   output logic [7:0]       req_offset,
   output logic [7:0]       req_wdata,
   input  logic             req_ready,
   input  logic             rsp_valid,
   input  logic             rsp_ok,
   input  logic [7:0]       rsp_rdata
);
   xfer_state_e      st;
   logic [TRY_W-1:0] tries;
   logic [TRY_W-1:0] lim_q;
   logic             ok_q;
   logic [7:0]       rdata_q;
   logic             wr_q;
   logic [7:0]       wdata_q;
   logic             gap_last;
   logic             out_of_tries;

   scdc_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
      .clk  (clk),
      .rst_n(rst_n),
      .load (st == XA_RSP && rsp_valid),
      .last (gap_last)
   );

   assign out_of_tries = (tries >= lim_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= XA_IDLE;
         tries   <= '0;
         lim_q   <= '0;
         ok_q    <= 1'b0;
         rdata_q <= '0;
         wr_q    <= 1'b0;
         wdata_q <= '0;
      end else begin
         case (st)
            XA_IDLE: begin
               if (go) begin
                  wr_q    <= go_write;
                  wdata_q <= go_wdata;
                  lim_q   <= go_tries;
                  tries   <= TRY_W'(1);
                  st      <= XA_REQ;
               end
            end
            XA_REQ: begin
               if (req_ready) st <= XA_RSP;
            end
            XA_RSP: begin
               if (rsp_valid) begin
                  ok_q    <= rsp_ok;
                  rdata_q <= rsp_rdata;
                  st      <= XA_GAP;
               end
            end
            XA_GAP: begin
               if (gap_last) begin
                  if (ok_q || out_of_tries) begin
                     st <= XA_IDLE;
                  end else begin
                     tries <= tries + TRY_W'(1);
                     st    <= XA_REQ;
                  end
               end
            end
            default: st <= XA_IDLE;
         endcase
      end
   end

   assign fin        = (st == XA_GAP) && gap_last && (ok_q || out_of_tries);
   assign fin_ok     = ok_q;
   assign fin_rdata  = rdata_q;
   assign req_valid  = (st == XA_REQ);
   assign req_write  = wr_q;
   assign req_dev    = DEV_ADDR;
   assign req_offset = REG_OFS;
   assign req_wdata  = wdata_q;
endmodule

// File: rtl/scdc_scramble_seq.sv
module scdc_scramble_seq
   import scdc_seq_pkg::*;
#(
   parameter int unsigned VER_W       = 32,
   parameter int unsigned VER_FIELD_W = 4,
   parameter int unsigned MIN_VER     = 4,
   parameter int unsigned RATE_W      = 32,
   parameter int unsigned THRESH_KHZ  = 340000,
   parameter logic [7:0]  DEV_ADDR    = 8'hA8,
   parameter logic [7:0]  REG_OFS     = 8'h20,
   parameter int unsigned RD_TRIES    = 3,
   parameter int unsigned WR_TRIES    = 2,
   parameter int unsigned CLK_KHZ     = 250000,
   parameter int unsigned GAP_US      = 468,
   parameter int unsigned GAP_CYCLES  = (CLK_KHZ / 1000) * GAP_US
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [RATE_W-1:0] pix_khz,
   input  logic [VER_W-1:0]  tx_version,
   output logic              req_valid,
   output logic              req_write,
   output logic [7:0]        req_dev,
   output logic [7:0]        req_offset,
   output logic [7:0]        req_wdata,
   input  logic              req_ready,
   input  logic              rsp_valid,
   input  logic              rsp_ok,
   input  logic [7:0]        rsp_rdata,
   output logic              scramble_en,
   output logic              path_update,
   output logic              done,
   output logic              error,
   output logic              scramble_state
);
   localparam int unsigned MAX_TRIES = (RD_TRIES > WR_TRIES) ? RD_TRIES : WR_TRIES;
   localparam int unsigned TRY_W     = $clog2(MAX_TRIES + 1);

   generate
      if (RD_TRIES < 1 || WR_TRIES < 1) begin : g_bad_tries
         $error("attempt limits must be at least one");
      end
      if (VER_FIELD_W < 1 || VER_FIELD_W > VER_W) begin : g_bad_ver
         $error("version field must fit in the version word");
      end
      if (RATE_W < 1 || RATE_W > 32) begin : g_bad_rate
         $error("rate width must be 1 to 32 bits");
      end
   endgenerate

   seq_state_e       state;
   logic             hi_q;
   logic             err_q;
   logic             scr_en_q;
   logic             upd_q;
   logic             scr_state_q;
   logic             go_q;
   logic             go_wr_q;
   logic [7:0]       go_wdata_q;
   logic [TRY_W-1:0] go_tries_q;
   logic             ver_ok;
   logic             hi_rate;
   logic             fin;
   logic             fin_ok;
   logic [7:0]       fin_rdata;
   logic             accept;

   scdc_mode_gate #(
      .VER_W      (VER_W),
      .VER_FIELD_W(VER_FIELD_W),
      .MIN_VER    (MIN_VER),
      .RATE_W     (RATE_W),
      .THRESH_KHZ (THRESH_KHZ)
   ) u_gate (
      .tx_version(tx_version),
      .pix_khz   (pix_khz),
      .ver_ok    (ver_ok),
      .hi_rate   (hi_rate)
   );

   scdc_xfer_agent #(
      .DEV_ADDR  (DEV_ADDR),
      .REG_OFS   (REG_OFS),
      .TRY_W     (TRY_W),
      .GAP_CYCLES(GAP_CYCLES)
   ) u_agent (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go_q),
      .go_write  (go_wr_q),
      .go_wdata  (go_wdata_q),
      .go_tries  (go_tries_q),
      .fin       (fin),
      .fin_ok    (fin_ok),
      .fin_rdata (fin_rdata),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_dev   (req_dev),
      .req_offset(req_offset),
      .req_wdata (req_wdata),
      .req_ready (req_ready),
      .rsp_valid (rsp_valid),
      .rsp_ok    (rsp_ok),
      .rsp_rdata (rsp_rdata)
   );

   assign accept = start && (state == ST_IDLE || state == ST_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         hi_q        <= 1'b0;
         err_q       <= 1'b0;
         scr_en_q    <= 1'b0;
         upd_q       <= 1'b0;
         scr_state_q <= 1'b0;
         go_q        <= 1'b0;
         go_wr_q     <= 1'b0;
         go_wdata_q  <= '0;
         go_tries_q  <= '0;
      end else begin
         go_q <= 1'b0;
         if (accept) begin
            err_q       <= 1'b0;
            scr_en_q    <= 1'b0;
            upd_q       <= 1'b0;
            scr_state_q <= 1'b0;
            hi_q        <= hi_rate;
            if (!ver_ok) begin
               state <= ST_FIN;
            end else begin
               go_q       <= 1'b1;
               go_wr_q    <= 1'b0;
               go_tries_q <= TRY_W'(RD_TRIES);
               state      <= hi_rate ? ST_RD_RATIO : ST_RD_SCR;
            end
         end else begin
            case (state)
               ST_RD_RATIO: begin
                  if (fin) begin
                     if (fin_ok) begin
                        go_q       <= 1'b1;
                        go_wr_q    <= 1'b1;
                        go_wdata_q <= patch_bit(fin_rdata, RATIO_BIT, 1'b1);
                        go_tries_q <= TRY_W'(WR_TRIES);
                        state      <= ST_WR_RATIO;
                     end else begin
                        err_q <= 1'b1;
                        state <= ST_FIN;
                     end
                  end
               end
               ST_WR_RATIO: begin
                  if (fin) begin
                     if (fin_ok) begin
                        state <= ST_LOCAL;
                     end else begin
                        err_q <= 1'b1;
                        state <= ST_FIN;
                     end
                  end
               end
               ST_LOCAL: begin
                  scr_en_q   <= 1'b1;
                  upd_q      <= 1'b1;
                  go_q       <= 1'b1;
                  go_wr_q    <= 1'b0;
                  go_tries_q <= TRY_W'(RD_TRIES);
                  state      <= ST_RD_SCR;
               end
               ST_RD_SCR: begin
                  if (fin) begin
                     if (fin_ok) begin
                        go_q       <= 1'b1;
                        go_wr_q    <= 1'b1;
                        go_wdata_q <= patch_bit(fin_rdata, SCR_BIT, hi_q);
                        go_tries_q <= TRY_W'(WR_TRIES);
                        state      <= ST_WR_SCR;
                     end else begin
                        err_q <= 1'b1;
                        state <= ST_FIN;
                     end
                  end
               end
               ST_WR_SCR: begin
                  if (fin) begin
                     if (fin_ok) begin
                        scr_state_q <= hi_q;
                     end else begin
                        err_q <= 1'b1;
                     end
                     state <= ST_FIN;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign scramble_en    = scr_en_q;
   assign path_update    = upd_q;
   assign done           = (state == ST_FIN);
   assign error          = err_q;
   assign scramble_state = scr_state_q;
endmodule

// File: rtl/scdc_scramble_seq_chk.sv
module scdc_scramble_seq_chk #(
   parameter int unsigned GAP_CYCLES = 117000,
   parameter logic [7:0]  DEV_ADDR   = 8'hA8,
   parameter logic [7:0]  REG_OFS    = 8'h20
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       req_valid,
   input logic       req_write,
   input logic [7:0] req_dev,
   input logic [7:0] req_offset,
   input logic [7:0] req_wdata,
   input logic       req_ready,
   input logic       rsp_valid,
   input logic       scramble_en,
   input logic       path_update,
   input logic       done,
   input logic       error,
   input logic       scramble_state
);
   localparam int unsigned CW = $clog2(GAP_CYCLES + 2);

   logic [CW-1:0] since_rsp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rsp <= CW'(GAP_CYCLES);
      end else if (rsp_valid) begin
         since_rsp <= '0;
      end else if (since_rsp < CW'(GAP_CYCLES)) begin
         since_rsp <= since_rsp + 1'b1;
      end
   end

   p_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_dev == DEV_ADDR && req_offset == REG_OFS));

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_write) && $stable(req_wdata)));

   p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> (since_rsp >= CW'(GAP_CYCLES)));

   p_quiet_when_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_valid);

   p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(error) && $stable(scramble_state)));

   p_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
      scramble_state |-> (scramble_en && path_update && !error));

   p_local_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      scramble_en == path_update);
endmodule

bind scdc_scramble_seq scdc_scramble_seq_chk #(
   .GAP_CYCLES(GAP_CYCLES),
   .DEV_ADDR  (DEV_ADDR),
   .REG_OFS   (REG_OFS)
) u_chk (.*);

// File: tb/sim_scdc_scramble_seq.sv
module sim_scdc_scramble_seq;
   localparam int GAP = 6;
   localparam logic [31:0] V4 = 32'h4000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] pix_khz = '0;
   logic [31:0] tx_version = '0;
   logic        req_valid, req_write;
   logic [7:0]  req_dev, req_offset, req_wdata;
   logic        req_ready = 1'b0;
   logic        rsp_valid = 1'b0;
   logic        rsp_ok = 1'b0;
   logic [7:0]  rsp_rdata = '0;
   logic        scramble_en, path_update, done, error, scramble_state;

   always #2 clk = ~clk;

   scdc_scramble_seq #(.GAP_CYCLES(GAP)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .pix_khz(pix_khz),
      .tx_version(tx_version), .req_valid(req_valid), .req_write(req_write),
      .req_dev(req_dev), .req_offset(req_offset), .req_wdata(req_wdata),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
      .rsp_rdata(rsp_rdata), .scramble_en(scramble_en), .path_update(path_update),
      .done(done), .error(error), .scramble_state(scramble_state)
   );

   // sink model and transaction log
   int          cyc = 0;
   int          xfer_n = 0;
   int          last_rsp_cyc = 0;
   logic [127:0] fail_vec = '0;
   logic        cfg_ld = 1'b0;
   logic [7:0]  cfg_load = '0;
   logic [7:0]  cfg = '0;
   logic        pend = 1'b0;
   int          dly = 0;
   logic        ok_hold = 1'b0;
   logic        lg_wr  [0:127];
   logic [7:0]  lg_dev [0:127];
   logic [7:0]  lg_off [0:127];
   logic [7:0]  lg_dat [0:127];
   logic        lg_se  [0:127];
   int          lg_gap [0:127];

   always @(posedge clk) begin
      cyc       <= cyc + 1;
      rsp_valid <= 1'b0;
      if (cfg_ld) cfg <= cfg_load;
      req_ready <= req_valid && !req_ready && !pend;
      if (req_valid && req_ready) begin
         lg_wr[xfer_n]  <= req_write;
         lg_dev[xfer_n] <= req_dev;
         lg_off[xfer_n] <= req_offset;
         lg_dat[xfer_n] <= req_wdata;
         lg_se[xfer_n]  <= scramble_en;
         lg_gap[xfer_n] <= cyc - last_rsp_cyc;
         ok_hold        <= !fail_vec[xfer_n];
         if (req_write && !fail_vec[xfer_n]) cfg <= req_wdata;
         pend   <= 1'b1;
         dly    <= 2;
         xfer_n <= xfer_n + 1;
      end else if (pend) begin
         if (dly == 0) begin
            rsp_valid    <= 1'b1;
            rsp_ok       <= ok_hold;
            rsp_rdata    <= cfg;
            pend         <= 1'b0;
            last_rsp_cyc <= cyc;
         end else begin
            dly <= dly - 1;
         end
      end
   end

   int n_chk = 0;
   int n_bad = 0;
   int done_cyc = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [7:0] v);
      @(negedge clk) cfg_load = v; cfg_ld = 1'b1;
      @(negedge clk) cfg_ld = 1'b0;
   endtask

   task automatic launch(input logic [31:0] ver, input logic [31:0] khz,
                         output int base, output bit got);
      base = xfer_n;
      @(negedge clk);
      tx_version = ver; pix_khz = khz; start = 1'b1;
      @(negedge clk) start = 1'b0;
      got = 0;
      for (int i = 0; i < 3000; i++) begin
         if (done) begin got = 1; break; end
         @(negedge clk);
      end
      done_cyc = cyc;
   endtask

   task automatic chk_gaps(input int base, input int n, input string req);
      for (int i = base + 1; i < base + n; i++)
         chk(lg_gap[i] >= GAP, req, lg_gap[i], GAP);
      chk(done_cyc - last_rsp_cyc >= GAP, req, done_cyc - last_rsp_cyc, GAP);
   endtask

   task automatic t_reset;
      chk(!req_valid && !done && !error, "R9 reset idle", {req_valid, done, error}, 0);
      chk(!scramble_en && !path_update && !scramble_state, "R10 reset outputs",
          {scramble_en, path_update, scramble_state}, 0);
   endtask

   task automatic t_old_version;
      int b; bit g;
      launch(32'h3FFF_FFFF, 594000, b, g);
      chk(g && !error, "R1 gated done no error", {g, error}, 2);
      chk(xfer_n - b == 0, "R1 no request", xfer_n - b, 0);
      chk(!scramble_en && !path_update && !scramble_state, "R1 outputs idle",
          {scramble_en, path_update, scramble_state}, 0);
   endtask

   task automatic t_high_rate;
      int b; bit g;
      set_cfg(8'hC4);
      launch(V4, 594000, b, g);
      chk(g && !error && xfer_n - b == 4, "R5 high path count", xfer_n - b, 4);
      for (int i = b; i < b + 4; i++)
         chk(lg_dev[i] == 8'hA8 && lg_off[i] == 8'h20, "R3 target",
             {lg_dev[i], lg_off[i]}, 16'hA820);
      chk({lg_wr[b], lg_wr[b+1], lg_wr[b+2], lg_wr[b+3]} == 4'b0101, "R5 order",
          {lg_wr[b], lg_wr[b+1], lg_wr[b+2], lg_wr[b+3]}, 4'b0101);
      chk(lg_dat[b+1] == 8'hC6, "R4 ratio bit1 only", lg_dat[b+1], 8'hC6);
      chk(lg_dat[b+3] == 8'hC7, "R4 scramble bit0 only", lg_dat[b+3], 8'hC7);
      chk(!lg_se[b+1] && lg_se[b+2], "R5 local enable between", {lg_se[b+1], lg_se[b+2]}, 2'b01);
      chk(scramble_en && path_update && scramble_state, "R10 final state on",
          {scramble_en, path_update, scramble_state}, 3'b111);
      chk_gaps(b, 4, "R7 gap high path");
   endtask

   task automatic t_at_threshold;
      int b; bit g;
      set_cfg(8'h07);
      launch(V4, 340000, b, g);
      chk(g && !error && xfer_n - b == 2, "R2 threshold low path", xfer_n - b, 2);
      chk(!lg_wr[b] && lg_wr[b+1] && lg_dat[b+1] == 8'h06, "R8 clear bit0",
          lg_dat[b+1], 8'h06);
      chk(!scramble_en && !path_update && !scramble_state, "R8 local off",
          {scramble_en, path_update, scramble_state}, 0);
   endtask

   task automatic t_just_above;
      int b; bit g;
      set_cfg(8'h00);
      launch(32'hF000_0000, 340001, b, g);
      chk(g && !error && xfer_n - b == 4, "R2 above threshold high path", xfer_n - b, 4);
      chk(lg_dat[b+3] == 8'h03, "R4 cumulative byte", lg_dat[b+3], 8'h03);
   endtask

   task automatic t_read_retry;
      int b; bit g;
      set_cfg(8'hF1);
      fail_vec[xfer_n] = 1'b1; fail_vec[xfer_n+1] = 1'b1;
      launch(V4, 148500, b, g);
      chk(g && !error && xfer_n - b == 4, "R6 third read succeeds", xfer_n - b, 4);
      chk(lg_wr[b+3] && lg_dat[b+3] == 8'hF0, "R6 write after retries", lg_dat[b+3], 8'hF0);
      chk_gaps(b, 4, "R7 gap across retries");
   endtask

   task automatic t_read_exhaust;
      int b; bit g;
      fail_vec[xfer_n] = 1; fail_vec[xfer_n+1] = 1; fail_vec[xfer_n+2] = 1;
      launch(V4, 594000, b, g);
      chk(g && error && xfer_n - b == 3, "R6 three reads then error", xfer_n - b, 3);
      chk(!scramble_en && !scramble_state, "R10 off after error", {scramble_en, scramble_state}, 0);
      repeat (30) @(negedge clk);
      chk(done && error && xfer_n - b == 3, "R9 error held", {done, error}, 2'b11);
   endtask

   task automatic t_write_exhaust;
      int b; bit g;
      set_cfg(8'h01);
      b = xfer_n;
      fail_vec[b+1] = 1; fail_vec[b+2] = 1;
      @(negedge clk);
      tx_version = V4; pix_khz = 25200; start = 1'b1;
      @(negedge clk) start = 1'b0;
      @(negedge clk);
      chk(!error && !done, "R9 start clears error", {done, error}, 0);
      g = 0;
      for (int i = 0; i < 3000; i++) begin
         if (done) begin g = 1; break; end
         @(negedge clk);
      end
      chk(g && error && xfer_n - b == 3, "R6 two writes then error", xfer_n - b, 3);
   endtask

   task automatic t_ratio_retry;
      int b; bit g;
      set_cfg(8'h80);
      fail_vec[xfer_n+1] = 1'b1;
      launch(V4, 594000, b, g);
      chk(g && !error && xfer_n - b == 5, "R6 ratio write retried", xfer_n - b, 5);
      chk(lg_dat[b+2] == 8'h82 && lg_dat[b+4] == 8'h83, "R4 retry data",
          {lg_dat[b+2], lg_dat[b+4]}, 16'h8283);
      chk(scramble_state, "R10 success after retry", scramble_state, 1);
   endtask

   task automatic t_start_while_busy;
      int b; bit g;
      set_cfg(8'h10);
      b = xfer_n;
      @(negedge clk);
      tx_version = V4; pix_khz = 594000; start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int i = 0; i < 200; i++) begin
         if (rsp_valid) break;
         @(negedge clk);
      end
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      g = 0;
      for (int i = 0; i < 3000; i++) begin
         if (done) begin g = 1; break; end
         @(negedge clk);
      end
      repeat (40) @(negedge clk);
      chk(g && xfer_n - b == 4, "R9 start during response ignored", xfer_n - b, 4);
      chk(lg_dat[b+3] == 8'h13 && scramble_state, "R9 run completes", lg_dat[b+3], 8'h13);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_old_version;
      t_high_rate;
      t_at_threshold;
      t_just_above;
      t_read_retry;
      t_read_exhaust;
      t_write_exhaust;
      t_ratio_retry;
      t_start_while_busy;
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      wait (cyc > 150000);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule